// File: doc/BRIEF.md
# Width-Configurable Asynchronous SRAM Controller

This block lets a synchronous host use an array of four byte-wide asynchronous SRAM dies. Each die has its own byte lane and its own chip-enable and write-enable strobes. All four dies share a 19-bit address bus and one output-enable line. A static organisation input sets how the host sees the array: as one 32-bit memory, as a 16-bit memory twice as deep, or as an 8-bit memory four times as deep. In the narrower organisations the host address bits above the shared address bus choose which lanes are strobed. Unselected dies stay in standby.

The host issues one access at a time with a level request. The controller latches the access, decodes it into device address and lane enables, and drives the strobes. Every device minimum is covered by counting clock cycles, with the counts derived from the clock period by rounding up. It then pulses an acknowledge for one cycle. Write data is replicated across the selected lanes. Read data is returned right-aligned with the unused upper bits zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and while idle, every chip enable and write enable is high, output enable is high, the data bus is not driven and acknowledge is low.
- R2: With mode 0 (32-bit), a write strobes all four lanes, puts address bits 18:0 on the device address and drives the full 32-bit host word.
- R3: With mode 1 (16-bit), host address bit 19 = 0 selects lanes 0 and 1 (chip enables 4'b1100) and = 1 selects lanes 2 and 3 (4'b0011). Host data bits 15:0 are driven on both halves of the bus.
- R4: With mode 2 (8-bit), host address bits 20:19 = n strobe lane n only, and host data bits 7:0 are driven on all four lanes. Other lanes keep their contents. Mode 3 behaves as mode 0.
- R5: Read data is returned in the low bits of rdata_o: the full word in mode 0, the selected 16-bit half in mode 1 and the selected byte in mode 2, with the unused upper bits zero.
- R6: Chip enable and address are valid at least one cycle before write enable falls. Write enable stays low for exactly 2 cycles at 8 ns (covering 15 ns), and only where chip enable is low.
- R7: Write enable returns high one cycle before the address changes, the bus is released or the chip enables go high.
- R8: A read holds the selected chip enables and output enable low, with write enables high and the bus undriven, for 3 cycles at 8 ns (covering 17 ns). The data is sampled in the last of these cycles.
- R9: The bus is never driven while output enable is low. A write that follows a read starts driving the bus one cycle later than a write that follows a write.
- R10: Every request gives exactly one single-cycle acknowledge: at the 5th cycle after acceptance for a write that follows a write, and at the 4th for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Organisation: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit |
| req_i | input | 1 | Access request, held until acknowledged |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 21 | Host address |
| wdata_i | input | 32 | Host write data (low bits used in narrow modes) |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, right-aligned |
| mem_addr_o | output | 19 | Shared device address |
| mem_ce_no | output | 4 | Per-lane chip enable, active low |
| mem_we_no | output | 4 | Per-lane write enable, active low |
| mem_oe_no | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 32 | Data driven towards the dies |
| mem_dq_oe_o | output | 1 | Bus drive enable for mem_dq_o |
| mem_dq_i | input | 32 | Data returned by the dies |

## Verification
The bench writes and reads in each organisation with distinct data per lane and per half. Replication or lane selection bugs therefore show up as wrong bytes in a later full-width read of the same device word. Each of the four 8-bit lanes is written separately and then one lane is overwritten, which separates a wrong lane mask from a wrong byte order. A 16-bit store to each half, read back at full width, checks half ordering. A read followed by a write is compared with a write followed by a write to expose a missing dead cycle. The strobe cycle counts are measured against the values derived from 17 ns and 15 ns at an 8 ns clock.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ORG_X32 = 2'd0,
    ORG_X16 = 2'd1,
    ORG_X8  = 2'd2
  } org_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RWAIT
  } seq_e;

  function automatic org_e to_org(input logic [1:0] m);
    case (m)
      2'd1:    return ORG_X16;
      2'd2:    return ORG_X8;
      default: return ORG_X32;
    endcase
  endfunction

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode
  import sram_ctl_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DEV_AW = 19,
  localparam int unsigned SEL_W   = $clog2(LANES),
  localparam int unsigned HOST_AW = DEV_AW + SEL_W
) (
  input  logic [1:0]         mode_i,
  input  logic [HOST_AW-1:0] addr_i,
  output logic [DEV_AW-1:0]  dev_addr_o,
  output logic [LANES-1:0]   lane_en_o
);
  localparam int unsigned HALF = LANES / 2;

  org_e org;
  assign org        = to_org(mode_i);
  assign dev_addr_o = addr_i[DEV_AW-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hit_half, hit_byte;
    assign hit_half = ((i >= HALF) == addr_i[DEV_AW]);
    assign hit_byte = (addr_i[DEV_AW +: SEL_W] == SEL_W'(i));
    always_comb begin
      case (org)
        ORG_X16: lane_en_o[i] = hit_half;
        ORG_X8:  lane_en_o[i] = hit_byte;
        default: lane_en_o[i] = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/sram_wr_replicate.sv
module sram_wr_replicate
  import sram_ctl_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] bus_o
);
  localparam int unsigned HALF = LANES / 2;

  org_e org;
  assign org = to_org(mode_i);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      case (org)
        ORG_X16: bus_o[i*LANE_W +: LANE_W] = wdata_i[(i % HALF)*LANE_W +: LANE_W];
        ORG_X8:  bus_o[i*LANE_W +: LANE_W] = wdata_i[LANE_W-1:0];
        default: bus_o[i*LANE_W +: LANE_W] = wdata_i[i*LANE_W +: LANE_W];
      endcase
    end
  end

endmodule

// File: rtl/sram_rd_select.sv
module sram_rd_select
  import sram_ctl_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned SEL_W  = $clog2(LANES)
) (
  input  logic [1:0]        mode_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned HW = DATA_W / 2;

  org_e org;
  logic [HW-1:0]     half_d;
  logic [LANE_W-1:0] byte_d;

  assign org    = to_org(mode_i);
  assign half_d = sel_i[0] ? bus_i[HW +: HW] : bus_i[0 +: HW];
  assign byte_d = bus_i[sel_i*LANE_W +: LANE_W];

  always_comb begin
    case (org)
      ORG_X16: rdata_o = {{(DATA_W-HW){1'b0}}, half_d};
      ORG_X8:  rdata_o = {{(DATA_W-LANE_W){1'b0}}, byte_d};
      default: rdata_o = bus_i;
    endcase
  end

endmodule

// File: rtl/sram_timing_fsm.sv
module sram_timing_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned WP_CYC = 2,
  parameter int unsigned SU_CYC = 1,
  localparam int unsigned MAX_CYC = (RD_CYC > WP_CYC) ?
                                    ((RD_CYC > SU_CYC) ? RD_CYC : SU_CYC) :
                                    ((WP_CYC > SU_CYC) ? WP_CYC : SU_CYC),
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [LANES-1:0] lanes_i,
  output logic             accept_o,
  output logic             capture_o,
  output logic [LANES-1:0] ce_no,
  output logic [LANES-1:0] we_no,
  output logic             oe_no,
  output logic             dq_oe_o,
  output logic             ack_o
);
  seq_e             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LANES-1:0] lanes_q;
  logic             prev_rd_q;

  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_RWAIT) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      lanes_q   <= '0;
      prev_rd_q <= 1'b0;
      ce_no     <= '1;
      we_no     <= '1;
      oe_no     <= 1'b1;
      dq_oe_o   <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            lanes_q <= lanes_i;
            if (wr_i) begin
              if (prev_rd_q) begin
                state_q <= ST_TURN;  // dead cycle after a read
              end else begin
                ce_no   <= ~lanes_i;
                dq_oe_o <= 1'b1;
                cnt_q   <= CNT_W'(SU_CYC - 1);
                state_q <= ST_WSETUP;
              end
            end else begin
              ce_no   <= ~lanes_i;
              oe_no   <= 1'b0;
              cnt_q   <= CNT_W'(RD_CYC - 1);
              state_q <= ST_RWAIT;
            end
          end
        end
        ST_TURN: begin
          prev_rd_q <= 1'b0;
          ce_no     <= ~lanes_q;
          dq_oe_o   <= 1'b1;
          cnt_q     <= CNT_W'(SU_CYC - 1);
          state_q   <= ST_WSETUP;
        end
        ST_WSETUP: begin
          if (cnt_q == '0) begin
            we_no   <= ~lanes_q;
            cnt_q   <= CNT_W'(WP_CYC - 1);
            state_q <= ST_WPULSE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WPULSE: begin
          if (cnt_q == '0) begin
            we_no   <= '1;
            state_q <= ST_WHOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WHOLD: begin
          ce_no     <= '1;
          dq_oe_o   <= 1'b0;
          ack_o     <= 1'b1;
          prev_rd_q <= 1'b0;
          state_q   <= ST_IDLE;
        end
        ST_RWAIT: begin
          if (cnt_q == '0) begin
            ce_no     <= '1;
            oe_no     <= 1'b1;
            ack_o     <= 1'b1;
            prev_rd_q <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned LANES         = 4,
  parameter int unsigned LANE_W        = 8,
  parameter int unsigned DEV_AW        = 19,
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned T_RC_PS       = 17000,
  parameter int unsigned T_AA_PS       = 17000,
  parameter int unsigned T_WP_PS       = 15000,
  parameter int unsigned T_WC_PS       = 17000,
  parameter int unsigned SETUP_CYC     = 1,
  localparam int unsigned DATA_W  = LANES * LANE_W,
  localparam int unsigned SEL_W   = $clog2(LANES),
  localparam int unsigned HOST_AW = DEV_AW + SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               ack_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [DEV_AW-1:0]  mem_addr_o,
  output logic [LANES-1:0]   mem_ce_no,
  output logic [LANES-1:0]   mem_we_no,
  output logic               mem_oe_no,
  output logic [DATA_W-1:0]  mem_dq_o,
  output logic               mem_dq_oe_o,
  input  logic [DATA_W-1:0]  mem_dq_i
);
  localparam int unsigned SU_CYC  = (SETUP_CYC < 1) ? 1 : SETUP_CYC;
  localparam int unsigned RC_CYC  = ceil_div(T_RC_PS, CLK_PERIOD_PS);
  localparam int unsigned AA_CYC  = ceil_div(T_AA_PS, CLK_PERIOD_PS);
  localparam int unsigned RD_CYC  = (RC_CYC > AA_CYC) ? RC_CYC : AA_CYC;
  localparam int unsigned WPP_CYC = ceil_div(T_WP_PS, CLK_PERIOD_PS);
  localparam int unsigned WCR_CYC = ceil_div(T_WC_PS, CLK_PERIOD_PS);
  // write cycle spans setup + pulse + hold cycles
  localparam int unsigned WCP_CYC = (WCR_CYC > SU_CYC + 1) ? WCR_CYC - SU_CYC - 1 : 1;
  localparam int unsigned WP_CYC  = (WPP_CYC > WCP_CYC) ? WPP_CYC : WCP_CYC;

  logic [DEV_AW-1:0] dev_addr_d, dev_addr_q;
  logic [LANES-1:0]  lanes_d;
  logic [DATA_W-1:0] bus_wr_d, bus_wr_q;
  logic [DATA_W-1:0] rd_sel_d, rdata_q;
  logic [1:0]        mode_q;
  logic [SEL_W-1:0]  sel_q;
  logic              accept, capture;

  sram_lane_decode #(
    .LANES (LANES),
    .DEV_AW(DEV_AW)
  ) i_decode (
    .mode_i    (mode_i),
    .addr_i    (addr_i),
    .dev_addr_o(dev_addr_d),
    .lane_en_o (lanes_d)
  );

  sram_wr_replicate #(
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) i_wr_rep (
    .mode_i (mode_i),
    .wdata_i(wdata_i),
    .bus_o  (bus_wr_d)
  );

  sram_rd_select #(
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) i_rd_sel (
    .mode_i (mode_q),
    .sel_i  (sel_q),
    .bus_i  (mem_dq_i),
    .rdata_o(rd_sel_d)
  );

  sram_timing_fsm #(
    .LANES (LANES),
    .RD_CYC(RD_CYC),
    .WP_CYC(WP_CYC),
    .SU_CYC(SU_CYC)
  ) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .wr_i     (we_i),
    .lanes_i  (lanes_d),
    .accept_o (accept),
    .capture_o(capture),
    .ce_no    (mem_ce_no),
    .we_no    (mem_we_no),
    .oe_no    (mem_oe_no),
    .dq_oe_o  (mem_dq_oe_o),
    .ack_o    (ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_addr_q <= '0;
      bus_wr_q   <= '0;
      mode_q     <= '0;
      sel_q      <= '0;
    end else if (accept) begin
      dev_addr_q <= dev_addr_d;
      bus_wr_q   <= bus_wr_d;
      mode_q     <= mode_i;
      sel_q      <= addr_i[DEV_AW +: SEL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (capture) rdata_q <= rd_sel_d;
  end

  assign mem_addr_o = dev_addr_q;
  assign mem_dq_o   = bus_wr_q;
  assign rdata_o    = rdata_q;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DEV_AW = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              req_i,
  input logic              ack_o,
  input logic [DEV_AW-1:0] mem_addr_o,
  input logic [LANES-1:0]  mem_ce_no,
  input logic [LANES-1:0]  mem_we_no,
  input logic              mem_oe_no,
  input logic              mem_dq_oe_o
);
  localparam logic [LANES-1:0] ALL1 = '1;

  p_no_contention_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  p_we_within_ce_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~mem_we_no & mem_ce_no) == '0));

  p_write_bus_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_no != ALL1) |-> (mem_oe_no && mem_dq_oe_o));

  p_we_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_we_no != ALL1) && ($past(mem_we_no) == ALL1)) |->
      (($past(mem_ce_no) == mem_ce_no) && $stable(mem_addr_o)));

  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mem_we_no) != ALL1) |-> $stable(mem_addr_o));

  p_release_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mem_dq_oe_o) || ((mem_ce_no == ALL1) && ($past(mem_ce_no) != ALL1))) |->
      ($past(mem_we_no) == ALL1));

  p_read_strobes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> ((mem_we_no == ALL1) && (mem_ce_no != ALL1)));

  p_x8_one_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'd2) && (mem_ce_no != ALL1)) |-> ($countones(~mem_ce_no) == 1));

  p_x16_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'd1) && (mem_ce_no != ALL1)) |-> ($countones(~mem_ce_no) == LANES / 2));

  p_ack_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && (mem_ce_no == ALL1)) |-> (mem_we_no == ALL1 && !mem_dq_oe_o));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .LANES (LANES),
  .DEV_AW(DEV_AW)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .req_i      (req_i),
  .ack_o      (ack_o),
  .mem_addr_o (mem_addr_o),
  .mem_ce_no  (mem_ce_no),
  .mem_we_no  (mem_we_no),
  .mem_oe_no  (mem_oe_no),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [20:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ack_o;
  logic [31:0] rdata_o;
  logic [18:0] mem_addr_o;
  logic [3:0]  mem_ce_no, mem_we_no;
  logic        mem_oe_no, mem_dq_oe_o;
  logic [31:0] mem_dq_o;
  logic [31:0] mem_dq_i = '0;

  int checks = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o),
    .mem_addr_o(mem_addr_o), .mem_ce_no(mem_ce_no), .mem_we_no(mem_we_no),
    .mem_oe_no(mem_oe_no), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i(mem_dq_i)
  );

  // four byte-wide dies, sparse storage
  logic [7:0] store [int];
  always @(negedge clk_i) begin
    for (int g = 0; g < 4; g++) begin
      int k;
      k = g * 524288 + int'(mem_addr_o);
      if (!mem_ce_no[g] && !mem_we_no[g]) store[k] = mem_dq_o[g*8 +: 8];
      if (!mem_ce_no[g] && !mem_oe_no)
        mem_dq_i[g*8 +: 8] = store.exists(k) ? store[k] : 8'h00;
      else
        mem_dq_i[g*8 +: 8] = 8'h5A;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // measurements from the last access
  int w_ce_first, w_we_first, w_we_len, w_drive_first, w_ack_cyc;
  logic [3:0]  w_ce_pat, w_we_pat;
  logic [31:0] w_dq;
  logic [18:0] w_addr;
  logic        w_rel_ok, w_oe_ok;
  int r_oe_len, r_ack_cyc;
  logic [3:0]  r_ce_pat;
  logic        r_ok;
  logic [31:0] r_data;

  task automatic do_write(input logic [1:0] m, input logic [20:0] a, input logic [31:0] d);
    logic [3:0]  pwe;
    logic [18:0] paddr;
    @(negedge clk_i);
    mode_i = m; we_i = 1'b1; addr_i = a; wdata_i = d; req_i = 1'b1;
    w_ce_first = -1; w_we_first = -1; w_we_len = 0; w_drive_first = -1; w_ack_cyc = -1;
    w_ce_pat = 4'hF; w_we_pat = 4'hF; w_dq = '0; w_addr = '0; w_rel_ok = 1'b1; w_oe_ok = 1'b1;
    pwe = 4'hF; paddr = mem_addr_o;
    for (int cyc = 1; cyc < 40; cyc++) begin
      @(negedge clk_i);
      if (mem_ce_no != 4'hF && w_ce_first < 0) w_ce_first = cyc;
      if (mem_dq_oe_o && w_drive_first < 0) w_drive_first = cyc;
      if (mem_dq_oe_o && !mem_oe_no) w_oe_ok = 1'b0;
      if (mem_we_no != 4'hF) begin
        if (w_we_first < 0) w_we_first = cyc;
        w_we_len++;
        w_we_pat = mem_we_no; w_ce_pat = mem_ce_no; w_dq = mem_dq_o; w_addr = mem_addr_o;
      end
      if (pwe != 4'hF && (mem_ce_no == 4'hF || !mem_dq_oe_o || mem_addr_o != paddr))
        w_rel_ok = 1'b0;
      pwe = mem_we_no; paddr = mem_addr_o;
      if (ack_o) begin
        w_ack_cyc = cyc;
        req_i = 1'b0;
        break;
      end
    end
    req_i = 1'b0;
    @(negedge clk_i);
    chk("R10 write ack single cycle", 32'(ack_o), 32'd0);
  endtask

  task automatic do_read(input logic [1:0] m, input logic [20:0] a);
    @(negedge clk_i);
    mode_i = m; we_i = 1'b0; addr_i = a; req_i = 1'b1;
    r_oe_len = 0; r_ack_cyc = -1; r_ce_pat = 4'hF; r_ok = 1'b1; r_data = '0;
    for (int cyc = 1; cyc < 40; cyc++) begin
      @(negedge clk_i);
      if (!mem_oe_no) begin
        r_oe_len++;
        r_ce_pat = mem_ce_no;
        if (mem_we_no != 4'hF || mem_dq_oe_o) r_ok = 1'b0;
      end
      if (ack_o) begin
        r_ack_cyc = cyc;
        r_data = rdata_o;
        req_i = 1'b0;
        break;
      end
    end
    req_i = 1'b0;
    @(negedge clk_i);
    chk("R10 read ack single cycle", 32'(ack_o), 32'd0);
  endtask

  task automatic test_reset();
    chk("R1 ce idle", 32'(mem_ce_no), 32'hF);
    chk("R1 we idle", 32'(mem_we_no), 32'hF);
    chk("R1 oe idle", 32'(mem_oe_no), 32'd1);
    chk("R1 bus idle", 32'(mem_dq_oe_o), 32'd0);
    chk("R1 ack idle", 32'(ack_o), 32'd0);
  endtask

  task automatic test_x32();
    do_write(2'd0, 21'h000123, 32'hA1B2C3D4);
    chk("R2 ce all lanes", 32'(w_ce_pat), 32'h0);
    chk("R2 we all lanes", 32'(w_we_pat), 32'h0);
    chk("R2 bus data", w_dq, 32'hA1B2C3D4);
    chk("R2 dev addr", 32'(w_addr), 32'h123);
    chk("R6 ce before we", 32'(w_we_first - w_ce_first), 32'd1);
    chk("R6 we pulse length", 32'(w_we_len), 32'd2);
    chk("R7 we released first", 32'(w_rel_ok), 32'd1);
    chk("R9 first drive after write/reset", 32'(w_drive_first), 32'd1);
    chk("R10 write ack cycle", 32'(w_ack_cyc), 32'd5);
    do_read(2'd0, 21'h000123);
    chk("R8 oe low cycles", 32'(r_oe_len), 32'd3);
    chk("R8 read strobes", 32'(r_ok), 32'd1);
    chk("R8 read ce", 32'(r_ce_pat), 32'h0);
    chk("R10 read ack cycle", 32'(r_ack_cyc), 32'd4);
    chk("R5 x32 readback", r_data, 32'hA1B2C3D4);
  endtask

  task automatic test_x16();
    do_write(2'd1, {2'b01, 19'h00456}, 32'hFFFFBEEF);
    chk("R3 upper half ce", 32'(w_ce_pat), 32'h3);
    chk("R3 upper half data", w_dq, 32'hBEEFBEEF);
    do_write(2'd1, {2'b00, 19'h00456}, 32'h00001234);
    chk("R3 lower half ce", 32'(w_ce_pat), 32'hC);
    chk("R3 lower half we", 32'(w_we_pat), 32'hC);
    do_read(2'd1, {2'b01, 19'h00456});
    chk("R5 x16 upper read", r_data, 32'h0000BEEF);
    chk("R3 x16 read ce", 32'(r_ce_pat), 32'h3);
    do_read(2'd1, {2'b00, 19'h00456});
    chk("R5 x16 lower read", r_data, 32'h00001234);
    do_read(2'd0, 21'h000456);
    chk("R5 x16 halves at x32", r_data, 32'hBEEF1234);
  endtask

  task automatic test_x8();
    for (int n = 0; n < 4; n++) begin
      do_write(2'd2, {2'(n), 19'h00789}, 32'h55555500 | 32'(8'h10 + n));
      chk("R4 x8 lane ce", 32'(w_ce_pat), 32'(~(4'b1 << n) & 4'hF));
      chk("R4 x8 replicated", w_dq, {4{8'(8'h10 + n)}});
    end
    for (int n = 0; n < 4; n++) begin
      do_read(2'd2, {2'(n), 19'h00789});
      chk("R5 x8 byte read", r_data, 32'(8'h10 + n));
    end
    do_write(2'd2, {2'd1, 19'h00789}, 32'h000000AA);
    do_read(2'd0, 21'h000789);
    chk("R4 other lanes kept", r_data, 32'h1312AA10);
    do_write(2'd3, 21'h0007A0, 32'h01020304);
    chk("R4 mode 3 as x32", 32'(w_ce_pat), 32'h0);
  endtask

  task automatic test_turnaround();
    do_read(2'd0, 21'h000123);
    chk("R9 read no drive", 32'(r_ok), 32'd1);
    do_write(2'd0, 21'h000124, 32'h0BADF00D);
    chk("R9 dead cycle after read", 32'(w_drive_first), 32'd2);
    chk("R9 no contention", 32'(w_oe_ok), 32'd1);
    chk("R10 ack after turnaround", 32'(w_ack_cyc), 32'd6);
    do_write(2'd0, 21'h000125, 32'h12345678);
    chk("R9 no dead cycle after write", 32'(w_drive_first), 32'd1);
    do_read(2'd0, 21'h000124);
    chk("R8 turnaround data kept", r_data, 32'h0BADF00D);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL R10 watchdog expired act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    test_reset();
    test_x32();
    test_x16();
    test_x8();
    test_turnaround();
    repeat (3) @(negedge clk_i);
    test_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule